// File: doc/BRIEF.md
# Host Command Register with Pin-Override Control

This block is the host-facing control front end of a block cipher device. A host reaches two byte-wide registers through an 8-bit bus qualified by an active-low chip select, active-low read and write enables and two address lines. The command register holds the chaining mode, battery back-up, encrypt/decrypt direction, parity-error output enable and activate controls. The status register collects sticky event flags raised by the rest of the device.

A pin-select input picks how the command bits are set. With it high, the host programs the command register over the bus. Four control pins then act as outputs that mirror their command bits. With it low, the same four pins act as inputs, and their levels replace the matching bits in the effective command seen by the cipher core. The stored register is left unchanged. Also with pin-select low, address line A1 chooses between the native mode and a compatibility mode. Once the compatibility mode is entered it is held until a master reset.

The master reset is active low and synchronous, so it needs a running clock. Bidirectional pins are modelled as input, output and output-enable triples. Two small state machines form the sequencing. The write-strobe machine has states WR_IDLE and WR_HOLD: a strobe moves WR_IDLE to WR_HOLD and commits one write, and releasing the strobe moves WR_HOLD back to WR_IDLE. The mode machine has states MD_NATIVE and MD_COMPAT: pin-select low with A1 high moves MD_NATIVE to MD_COMPAT, and only reset leaves MD_COMPAT.

Top module: `cmd_ctl_top`

## Requirements
- R1: While rst_n is low at a rising clock edge, the command register, the status register and the mode state are cleared. Afterwards, reads of both registers return 0x00, ctl_out is 0 and compat_mode is 0.
- R2: With pin_sel high and a0 high, a1=1 selects the status register and a1=0 selects the command register. With a0 low, neither register is reached whatever a1 is: no read drives the bus and no write changes a register.
- R3: bus_oe is high, in the same cycle, exactly when cs_n=0, rd_n=0, wr_n=1, pin_sel=1 and a0=1. bus_out then carries the selected register. Otherwise the bus is released, including when rd_n and wr_n are both low.
- R4: A write (cs_n=0 and wr_n=0 with the command register selected) captures bus_in at the first rising edge of the strobe. The new value is visible from the next cycle. A strobe held over several edges commits only once, and writes to the status register are ignored.
- R5: The command bit map is: bit 7 chaining mode, bit 5 battery back-up, bit 3 encrypt/decrypt, bit 2 key-parity-error output enable, bit 1 activate. Bits 6, 4 and 0 always read as 0.
- R6: With pin_sel high, ctl_oe is 1 and ctl_out[3:0] = {cmd[7], cmd[5], cmd[3], cmd[1]}. eff_cmd equals the stored command.
- R7: With pin_sel low, ctl_oe is 0 and eff_cmd bits 7, 5, 3 and 1 take ctl_in[3], ctl_in[2], ctl_in[1] and ctl_in[0]. Bit 2 keeps its stored value, and the stored register reappears unchanged when pin_sel returns high.
- R8: With pin_sel low, bus writes are ignored and reads do not drive the bus.
- R9: pin_sel low with a1 high at a rising edge sets compat_mode from the next cycle. It then stays set whatever the inputs are, until reset.
- R10: Each bit set in stat_evt at a rising edge sets the matching status bit. The bit is readable from the next cycle and stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Master reset, active low, synchronous |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read enable, active low |
| wr_n | input | 1 | Write enable, active low |
| a0 | input | 1 | Address bit 0, register space select |
| a1 | input | 1 | Address bit 1, status/command select or mode select |
| pin_sel | input | 1 | 1: bus programming, 0: pin programming |
| bus_in | input | 8 | Bus data driven by the host |
| bus_out | output | 8 | Read data driven to the host |
| bus_oe | output | 1 | Bus output enable |
| ctl_in | input | 4 | Control pin levels {chain, battery, direction, activate} |
| ctl_out | output | 4 | Mirrored command bits for the control pins |
| ctl_oe | output | 1 | Control pin output enable |
| stat_evt | input | 8 | Status event flags from the device core |
| eff_cmd | output | 8 | Effective command used by the device core |
| compat_mode | output | 1 | Compatibility mode latch |

## Verification
The assertions assume that the host keeps its inputs steady across each rising edge and moves them only between edges. They also assume reset is held for at least one full clock edge. The stimulus meets this by changing every input on the falling edge and by holding rst_n low for several cycles. A1 is kept low whenever pin_sel is low, except in the one test that enters compatibility mode, so the sticky latch is never set by accident. Each write strobe is released before the next cycle begins, except in the test that holds a strobe across several edges on purpose.

// File: rtl/cmdreg_pkg.sv
package cmdreg_pkg;

    localparam int DW       = 8;
    localparam int NPIN     = 4;

    localparam int B_CHAIN  = 7;
    localparam int B_BATT   = 5;
    localparam int B_DIR    = 3;
    localparam int B_KPE    = 2;
    localparam int B_ACT    = 1;

    localparam logic [DW-1:0] CMD_WMASK =
        (DW'(1) << B_CHAIN) | (DW'(1) << B_BATT) | (DW'(1) << B_DIR) |
        (DW'(1) << B_KPE)   | (DW'(1) << B_ACT);

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_CMD  = 2'd1,
        SEL_STAT = 2'd2
    } reg_sel_e;

    typedef enum logic {
        WR_IDLE = 1'b0,
        WR_HOLD = 1'b1
    } wr_state_e;

    typedef enum logic {
        MD_NATIVE = 1'b0,
        MD_COMPAT = 1'b1
    } md_state_e;

    // control pin index -> command bit position
    function automatic int pin_bit(input int idx);
        case (idx)
            3:       pin_bit = B_CHAIN;
            2:       pin_bit = B_BATT;
            1:       pin_bit = B_DIR;
            default: pin_bit = B_ACT;
        endcase
    endfunction

endpackage

// File: rtl/cmdreg_bus_decode.sv
module cmdreg_bus_decode
    import cmdreg_pkg::*;
(
    input  logic     pin_sel,
    input  logic     cs_n,
    input  logic     rd_n,
    input  logic     wr_n,
    input  logic     a0,
    input  logic     a1,
    output reg_sel_e sel,
    output logic     rd_act,
    output logic     wr_req
);

    always_comb begin
        if (pin_sel && a0) begin
            sel = a1 ? SEL_STAT : SEL_CMD;
        end else begin
            sel = SEL_NONE;
        end
    end

    // a write strobe always wins over a read strobe
    assign wr_req = !cs_n && !wr_n;
    assign rd_act = !cs_n && !rd_n && wr_n && (sel != SEL_NONE);

endmodule

// File: rtl/cmdreg_wr_fsm.sv
module cmdreg_wr_fsm
    import cmdreg_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_req,
    input  reg_sel_e sel,
    output logic     cmd_we
);

    wr_state_e state_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WR_IDLE;
        end else begin
            unique case (state_q)
                WR_IDLE: if (wr_req)  state_q <= WR_HOLD;
                WR_HOLD: if (!wr_req) state_q <= WR_IDLE;
                default:              state_q <= WR_IDLE;
            endcase
        end
    end

    // outputs: one commit on the first edge of a strobe
    always_comb begin
        cmd_we = 1'b0;
        unique case (state_q)
            WR_IDLE: cmd_we = wr_req && (sel == SEL_CMD);
            WR_HOLD: cmd_we = 1'b0;
            default: cmd_we = 1'b0;
        endcase
    end

endmodule

// File: rtl/cmdreg_store.sv
module cmdreg_store
    import cmdreg_pkg::*;
#(
    parameter int W  = DW,
    parameter int NP = NPIN
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_we,
    input  logic [W-1:0]  wdata,
    input  logic          pin_sel,
    input  logic [NP-1:0] pin_in,
    output logic [W-1:0]  stored_q,
    output logic [W-1:0]  eff_cmd,
    output logic [NP-1:0] pin_out
);

    logic [NP-1:0] ovr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stored_q <= '0;
        end else if (cmd_we) begin
            stored_q <= wdata & W'(CMD_WMASK);
        end
    end

    for (genvar gi = 0; gi < NP; gi++) begin : g_pin
        localparam int PB = pin_bit(gi);
        assign pin_out[gi] = stored_q[PB];
        assign ovr[gi]     = pin_sel ? stored_q[PB] : pin_in[gi];
    end

    always_comb begin
        eff_cmd = stored_q;
        for (int i = 0; i < NP; i++) begin
            eff_cmd[pin_bit(i)] = ovr[i];
        end
    end

endmodule

// File: rtl/cmdreg_mode_latch.sv
module cmdreg_mode_latch
    import cmdreg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin_sel,
    input  logic a1,
    output logic compat
);

    md_state_e state_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= MD_NATIVE;
        end else begin
            unique case (state_q)
                MD_NATIVE: if (!pin_sel && a1) state_q <= MD_COMPAT;
                MD_COMPAT:                     state_q <= MD_COMPAT;
                default:                       state_q <= MD_NATIVE;
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            MD_NATIVE: compat = 1'b0;
            MD_COMPAT: compat = 1'b1;
            default:   compat = 1'b0;
        endcase
    end

endmodule

// File: rtl/cmdreg_status.sv
module cmdreg_status #(
    parameter int W = cmdreg_pkg::DW
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    output logic [W-1:0] stat_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= stat_q | evt;
        end
    end

endmodule

// File: rtl/cmd_ctl_top.sv
module cmd_ctl_top
    import cmdreg_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cs_n,
    input  logic            rd_n,
    input  logic            wr_n,
    input  logic            a0,
    input  logic            a1,
    input  logic            pin_sel,
    input  logic [DW-1:0]   bus_in,
    output logic [DW-1:0]   bus_out,
    output logic            bus_oe,
    input  logic [NPIN-1:0] ctl_in,
    output logic [NPIN-1:0] ctl_out,
    output logic            ctl_oe,
    input  logic [DW-1:0]   stat_evt,
    output logic [DW-1:0]   eff_cmd,
    output logic            compat_mode
);

    reg_sel_e        sel;
    logic            rd_act;
    logic            wr_req;
    logic            cmd_we;
    logic [DW-1:0]   cmd_q;
    logic [DW-1:0]   stat_q;

    cmdreg_bus_decode u_dec (
        .pin_sel (pin_sel),
        .cs_n    (cs_n),
        .rd_n    (rd_n),
        .wr_n    (wr_n),
        .a0      (a0),
        .a1      (a1),
        .sel     (sel),
        .rd_act  (rd_act),
        .wr_req  (wr_req)
    );

    cmdreg_wr_fsm u_wr (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_req (wr_req),
        .sel    (sel),
        .cmd_we (cmd_we)
    );

    cmdreg_store #(.W(DW), .NP(NPIN)) u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_we   (cmd_we),
        .wdata    (bus_in),
        .pin_sel  (pin_sel),
        .pin_in   (ctl_in),
        .stored_q (cmd_q),
        .eff_cmd  (eff_cmd),
        .pin_out  (ctl_out)
    );

    cmdreg_mode_latch u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_sel (pin_sel),
        .a1      (a1),
        .compat  (compat_mode)
    );

    cmdreg_status #(.W(DW)) u_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (stat_evt),
        .stat_q (stat_q)
    );

    always_comb begin
        bus_out = '0;
        if (rd_act) begin
            bus_out = (sel == SEL_STAT) ? stat_q : cmd_q;
        end
    end

    assign bus_oe = rd_act;
    assign ctl_oe = pin_sel;

endmodule

// File: rtl/cmdreg_checker.sv
module cmdreg_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       rd_n,
    input logic       wr_n,
    input logic       a0,
    input logic       a1,
    input logic       pin_sel,
    input logic       bus_oe,
    input logic [3:0] ctl_in,
    input logic [3:0] ctl_out,
    input logic       ctl_oe,
    input logic [7:0] eff_cmd,
    input logic       compat_mode
);

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!compat_mode && ctl_out == 4'b0000));

    assert_bus_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> (!cs_n && !rd_n && wr_n && pin_sel && a0));

    assert_rsv_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_cmd[6] == 1'b0 && eff_cmd[4] == 1'b0 && eff_cmd[0] == 1'b0));

    assert_mirror_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pin_sel |-> (ctl_oe &&
            ctl_out == {eff_cmd[7], eff_cmd[5], eff_cmd[3], eff_cmd[1]}));

    assert_override_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_sel |-> (!ctl_oe &&
            ctl_in == {eff_cmd[7], eff_cmd[5], eff_cmd[3], eff_cmd[1]}));

    assert_no_pin_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_sel |=> $stable(ctl_out));

    assert_compat_enter_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!pin_sel && a1) |=> compat_mode);

    assert_compat_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        compat_mode |=> compat_mode);

endmodule

bind cmd_ctl_top cmdreg_checker u_cmdreg_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n        (cs_n),
    .rd_n        (rd_n),
    .wr_n        (wr_n),
    .a0          (a0),
    .a1          (a1),
    .pin_sel     (pin_sel),
    .bus_oe      (bus_oe),
    .ctl_in      (ctl_in),
    .ctl_out     (ctl_out),
    .ctl_oe      (ctl_oe),
    .eff_cmd     (eff_cmd),
    .compat_mode (compat_mode)
);

// File: tb/test_cmd_ctl_top.sv
module test_cmd_ctl_top;

    localparam int CLK_T = 10;
    localparam int NVEC  = 18;

    typedef struct packed {
        logic       rd;
        logic       psel;
        logic       a1;
        logic       a0;
        logic [7:0] d;
        logic       eoe;
        logic [7:0] ed;
    } vec_t;

    // rd, psel, a1, a0, write data, expected oe, expected read data
    localparam vec_t VEC [NVEC] = '{
        '{1'b1, 1'b1, 1'b0, 1'b1, 8'h00, 1'b1, 8'h00},
        '{1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 1'b1, 8'h00},
        '{1'b0, 1'b1, 1'b0, 1'b1, 8'hFF, 1'b0, 8'h00},
        '{1'b1, 1'b1, 1'b0, 1'b1, 8'h00, 1'b1, 8'hAE},
        '{1'b0, 1'b1, 1'b1, 1'b1, 8'h55, 1'b0, 8'h00},
        '{1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 1'b1, 8'h00},
        '{1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00},
        '{1'b1, 1'b1, 1'b0, 1'b1, 8'h00, 1'b1, 8'hAE},
        '{1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00},
        '{1'b0, 1'b1, 1'b0, 1'b1, 8'h2A, 1'b0, 8'h00},
        '{1'b1, 1'b1, 1'b0, 1'b1, 8'h00, 1'b1, 8'h2A},
        '{1'b0, 1'b1, 1'b0, 1'b1, 8'h51, 1'b0, 8'h00},
        '{1'b1, 1'b1, 1'b0, 1'b1, 8'h00, 1'b1, 8'h00},
        '{1'b0, 1'b1, 1'b0, 1'b1, 8'h84, 1'b0, 8'h00},
        '{1'b1, 1'b1, 1'b0, 1'b1, 8'h00, 1'b1, 8'h84},
        '{1'b0, 1'b0, 1'b0, 1'b1, 8'hFF, 1'b0, 8'h00},
        '{1'b1, 1'b0, 1'b0, 1'b1, 8'h00, 1'b0, 8'h00},
        '{1'b1, 1'b1, 1'b0, 1'b1, 8'h00, 1'b1, 8'h84}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       rd_n = 1'b1;
    logic       wr_n = 1'b1;
    logic       a0 = 1'b0;
    logic       a1 = 1'b0;
    logic       pin_sel = 1'b1;
    logic [7:0] bus_in = 8'h00;
    logic [7:0] bus_out;
    logic       bus_oe;
    logic [3:0] ctl_in = 4'b0000;
    logic [3:0] ctl_out;
    logic       ctl_oe;
    logic [7:0] stat_evt = 8'h00;
    logic [7:0] eff_cmd;
    logic       compat_mode;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_T/2) clk = ~clk;

    cmd_ctl_top i_cmd_ctl_top (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n        (cs_n),
        .rd_n        (rd_n),
        .wr_n        (wr_n),
        .a0          (a0),
        .a1          (a1),
        .pin_sel     (pin_sel),
        .bus_in      (bus_in),
        .bus_out     (bus_out),
        .bus_oe      (bus_oe),
        .ctl_in      (ctl_in),
        .ctl_out     (ctl_out),
        .ctl_oe      (ctl_oe),
        .stat_evt    (stat_evt),
        .eff_cmd     (eff_cmd),
        .compat_mode (compat_mode)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic ps, input logic aa1, input logic aa0, input logic [7:0] d);
        @(negedge clk);
        pin_sel = ps; a1 = aa1; a0 = aa0; bus_in = d;
        cs_n = 1'b0; wr_n = 1'b0;
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1; pin_sel = 1'b1; a1 = 1'b0; a0 = 1'b0;
    endtask

    task automatic bus_read(input logic ps, input logic aa1, input logic aa0,
                            output logic oe, output logic [7:0] d);
        @(negedge clk);
        pin_sel = ps; a1 = aa1; a0 = aa0;
        cs_n = 1'b0; rd_n = 1'b0;
        #1;
        oe = bus_oe; d = bus_out;
        cs_n = 1'b1; rd_n = 1'b1; pin_sel = 1'b1; a1 = 1'b0; a0 = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_T * 20000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        logic       oe;
        logic [7:0] d;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 / R3: state after reset
        check("R1 compat after reset", compat_mode, 0);
        check("R1 ctl_out after reset", ctl_out, 0);
        check("R1 eff_cmd after reset", eff_cmd, 0);
        check("R3 bus idle after reset", bus_oe, 0);

        // R2 R3 R4 R5 R8: vector walk
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i].rd) begin
                bus_read(VEC[i].psel, VEC[i].a1, VEC[i].a0, oe, d);
                check($sformatf("R2/R3/R8 vector %0d oe", i), oe, VEC[i].eoe);
                if (VEC[i].eoe) begin
                    check($sformatf("R2/R4/R5 vector %0d data", i), d, VEC[i].ed);
                end
            end else begin
                bus_write(VEC[i].psel, VEC[i].a1, VEC[i].a0, VEC[i].d);
            end
        end

        // R6: mirroring with stored 0x84
        #1;
        check("R6 ctl_oe high", ctl_oe, 1);
        check("R6 ctl_out mirror", ctl_out, 4'b1000);
        check("R6 eff_cmd equals stored", eff_cmd, 8'h84);

        // R7: pin override
        @(negedge clk);
        pin_sel = 1'b0; ctl_in = 4'b0101;
        #1;
        check("R7 ctl_oe low", ctl_oe, 0);
        check("R7 eff_cmd override", eff_cmd, 8'h26);
        @(negedge clk);
        pin_sel = 1'b1;
        #1;
        check("R7 stored kept", eff_cmd, 8'h84);

        bus_write(1'b1, 1'b0, 1'b1, 8'hAE);
        #1;
        check("R6 ctl_out all set", ctl_out, 4'b1111);

        // R4: held strobe commits once
        @(negedge clk);
        a0 = 1'b1; a1 = 1'b0; bus_in = 8'h02; cs_n = 1'b0; wr_n = 1'b0;
        @(negedge clk);
        bus_in = 8'h80;
        repeat (2) @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1; a0 = 1'b0;
        bus_read(1'b1, 1'b0, 1'b1, oe, d);
        check("R4 single commit", d, 8'h02);

        // R3 / R4: read and write both low
        @(negedge clk);
        a0 = 1'b1; bus_in = 8'h08; cs_n = 1'b0; wr_n = 1'b0; rd_n = 1'b0;
        #1;
        check("R3 no drive on rd+wr", bus_oe, 0);
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1; a0 = 1'b0;
        bus_read(1'b1, 1'b0, 1'b1, oe, d);
        check("R4 write wins", d, 8'h08);

        // R10: sticky status
        @(negedge clk);
        stat_evt = 8'h81;
        @(negedge clk);
        stat_evt = 8'h10;
        @(negedge clk);
        stat_evt = 8'h00;
        bus_read(1'b1, 1'b1, 1'b1, oe, d);
        check("R10 status set", d, 8'h91);
        repeat (3) @(negedge clk);
        bus_read(1'b1, 1'b1, 1'b1, oe, d);
        check("R10 status held", d, 8'h91);

        // R9: compatibility latch
        check("R9 native before entry", compat_mode, 0);
        @(negedge clk);
        pin_sel = 1'b0; a1 = 1'b1;
        @(negedge clk);
        check("R9 compat entered", compat_mode, 1);
        pin_sel = 1'b1; a1 = 1'b0;
        repeat (3) @(negedge clk);
        check("R9 compat sticky", compat_mode, 1);

        // R1: reset clears everything
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 compat cleared", compat_mode, 0);
        check("R1 ctl_out cleared", ctl_out, 0);
        bus_read(1'b1, 1'b0, 1'b1, oe, d);
        check("R1 command cleared", d, 8'h00);
        bus_read(1'b1, 1'b1, 1'b1, oe, d);
        check("R1 status cleared", d, 8'h00);

        finish_run();
    end

endmodule